// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken and computes where it goes. It looks at the four processor status flags (negative, zero, carry and overflow) and at the branch's 4-bit condition code. The three low bits of the code select one of eight base tests. The top bit inverts the result of that test, so the eight base tests give sixteen conditions. The signed comparisons use the exclusive-or of the negative and overflow flags.

The target is the address of the next sequential instruction (PC + 4) plus a sign-extended 23-bit byte displacement. The sum wraps modulo 2^32.

A request is presented with a one-cycle valid strobe. The decision and the target are registered on that edge and appear together with a one-cycle done pulse. They then hold until the next strobe. The block does not generate the flags and does not fetch the target instruction.

Top module: `brCondUnit`

## Requirements
- R1: Code 4'b0000 is always taken. Code 4'b1000 is never taken, even when all four flags are 1.
- R2: Code 4'b0001 is taken when C=0, and code 4'b1001 is taken when C=1.
- R3: Code 4'b0010 is taken when V=0, and code 4'b1010 is taken when V=1.
- R4: Code 4'b0011 is taken when Z=1, and code 4'b1011 is taken when Z=0.
- R5: Code 4'b0100 (signed greater-or-equal) is taken when N equals V. Code 4'b1100 (signed less-than) is taken when N differs from V.
- R6: Code 4'b0101 (signed greater-than) is taken when Z=0 and N equals V. Code 4'b1101 (signed less-or-equal) is taken when Z=1 or N differs from V.
- R7: Code 4'b0110 is taken when N=0, and code 4'b1110 is taken when N=1.
- R8: Code 4'b0111 is never taken and code 4'b1111 is always taken, whatever the flags.
- R9: target equals pc + 4 + the sign-extended 23-bit disp (bit 22 is the sign), taken modulo 2^32.
- R10: A reqValid sampled high at a rising edge makes taken, target and done update at that edge. done is high for exactly the cycles that follow a cycle with reqValid high.
- R11: While reqValid is low, taken and target hold their values whatever the other inputs do.
- R12: While rstN is low, done, taken and target are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| cond | input | 4 | Branch condition code |
| pc | input | 32 | Address of the branch instruction |
| disp | input | 23 | Signed byte displacement |
| done | output | 1 | One-cycle result pulse |
| taken | output | 1 | Branch decision |
| target | output | 32 | Computed branch target |

## Verification
Every one of the sixteen codes is tried with all sixteen flag combinations. This separates each code from its inverted partner and exposes any base test that reads the wrong flag. It also shows whether the signed tests use the N/V relation rather than N alone. The target is tried with positive, negative, zero and extreme displacements, and with a PC near the top of the address space, which shows whether sign extension and wrap-around are correct. Back-to-back strobes, idle gaps and inputs that change while reqValid is low show whether the pulse is timed correctly and whether the outputs hold.

// File: rtl/brCondPkg.sv
package brCondPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
  } brStrobes_t;

  // Base tests selected by cond[2:0]; cond[3] inverts the result
  typedef enum logic [2:0] {
    BASE_ALWAYS = 3'd0,
    BASE_NOCARRY = 3'd1,
    BASE_NOOVF = 3'd2,
    BASE_ZERO = 3'd3,
    BASE_SGE = 3'd4,
    BASE_SGT = 3'd5,
    BASE_PLUS = 3'd6,
    BASE_FALSE = 3'd7
  } baseTest_e;
endpackage

// File: rtl/brCondEval.sv
module brCondEval
  import brCondPkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  input  logic [COND_W-1:0] cond,
  output logic              isTaken
);
  localparam int INV_BIT = COND_W - 1;

  baseTest_e baseSel;
  logic baseHit;
  logic signedGe;

  assign baseSel  = baseTest_e'(cond[2:0]);
  assign signedGe = ~(flagN ^ flagV);

  always_comb begin
    unique case (baseSel)
      BASE_ALWAYS:  baseHit = 1'b1;
      BASE_NOCARRY: baseHit = ~flagC;
      BASE_NOOVF:   baseHit = ~flagV;
      BASE_ZERO:    baseHit = flagZ;
      BASE_SGE:     baseHit = signedGe;
      BASE_SGT:     baseHit = ~flagZ & signedGe;
      BASE_PLUS:    baseHit = ~flagN;
      BASE_FALSE:   baseHit = 1'b0;
      default:      baseHit = 1'b0;
    endcase
  end

  assign isTaken = baseHit ^ cond[INV_BIT];
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brCondPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 23,
  parameter int COND_W = 4,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  brStrobes_t        strb,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  input  logic [COND_W-1:0] cond,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic              takenNext;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] targetNext;

  brCondEval #(.COND_W(COND_W)) i_eval (
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .flagV  (flagV),
    .cond   (cond),
    .isTaken(takenNext)
  );

  assign dispExt    = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign targetNext = pc + STEP_V + dispExt;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      taken  <= 1'b0;
      target <= '0;
    end else if (strb.load) begin
      taken  <= takenNext;
      target <= targetNext;
    end
  end
endmodule

// File: rtl/brControl.sv
module brControl
  import brCondPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output brStrobes_t strb,
  output logic       done
);
  assign strb.clear = ~rstN;
  assign strb.load  = rstN & reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= reqValid;
  end
endmodule

// File: rtl/brCondUnit.sv
module brCondUnit
  import brCondPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 23,
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  input  logic [COND_W-1:0] cond,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  brStrobes_t strb;

  brControl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strb    (strb),
    .done    (done)
  );

  brDatapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .COND_W(COND_W), .STEP(4)) i_dp (
    .clk   (clk),
    .strb  (strb),
    .flagN (flagN),
    .flagZ (flagZ),
    .flagC (flagC),
    .flagV (flagV),
    .cond  (cond),
    .pc    (pc),
    .disp  (disp),
    .taken (taken),
    .target(target)
  );
endmodule

// File: rtl/brCondUnitChecker.sv
module brCondUnitChecker #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 23,
  parameter int COND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              flagV,
  input logic [COND_W-1:0] cond,
  input logic [ADDR_W-1:0] pc,
  input logic [DISP_W-1:0] disp,
  input logic              done,
  input logic              taken,
  input logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] dispWide;
  assign dispWide = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

  p_never_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cond == 4'b1000) |=> !taken);
  p_always_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cond == 4'b0000) |=> taken);
  p_eq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cond == 4'b0011) |=> (taken == $past(flagZ)));
  p_le_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cond == 4'b1101) |=> (taken == ($past(flagZ) | ($past(flagN) ^ $past(flagV)))));
  p_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cond[2:0] == 3'b111) |=> (taken == $past(cond[3])));
  p_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (target == $past(pc) + ADDR_W'(4) + $past(dispWide)));
  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done);
  p_nodone_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(taken) && $stable(target)));
  p_reset_r12: assert property (@(posedge clk)
    !rstN |=> (!done && !taken && target == '0));
endmodule

bind brCondUnit brCondUnitChecker #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .COND_W(COND_W)) i_chk (.*);

// File: tb/test_brCondUnit.sv
module test_brCondUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic [3:0]  cond = '0;
  logic [31:0] pc = '0;
  logic [22:0] disp = '0;
  logic        done, taken;
  logic [31:0] target;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  brCondUnit i_brCondUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .cond(cond), .pc(pc), .disp(disp),
    .done(done), .taken(taken), .target(target)
  );

  function automatic logic refTaken(logic [3:0] c, logic [3:0] f);
    // f = {N, Z, C, V}
    logic b;
    case (c[2:0])
      3'd0: b = 1'b1;
      3'd1: b = !f[1];
      3'd2: b = !f[0];
      3'd3: b = f[2];
      3'd4: b = (f[3] == f[0]);
      3'd5: b = !f[2] && (f[3] == f[0]);
      3'd6: b = !f[3];
      default: b = 1'b0;
    endcase
    return b ^ c[3];
  endfunction

  function automatic string reqOf(logic [3:0] c);
    case (c[2:0])
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge; results are valid at the next falling edge
  task automatic issue(logic [3:0] c, logic [3:0] f, logic [31:0] p, logic [22:0] d);
    @(negedge clk);
    cond = c; {flagN, flagZ, flagC, flagV} = f; pc = p; disp = d;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    reqValid = 1'b1;
    cond = 4'b0000;
    pc = 32'h100;
    repeat (3) @(negedge clk);
    check("R12", "done in reset", {31'b0, done}, 32'd0);
    check("R12", "taken in reset", {31'b0, taken}, 32'd0);
    check("R12", "target in reset", target, 32'd0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testAllConditions();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        issue(4'(c), 4'(f), 32'h40, 23'd8);
        check(reqOf(4'(c)), $sformatf("taken cond=%b flags=%b", 4'(c), 4'(f)),
              {31'b0, taken}, {31'b0, refTaken(4'(c), 4'(f))});
      end
    end
    // R1: never with all flags set
    issue(4'b1000, 4'b1111, 32'h0, 23'd0);
    check("R1", "never with all flags", {31'b0, taken}, 32'd0);
  endtask

  task automatic testTarget();
    issue(4'b0000, 4'b0000, 32'h0000_1000, 23'h000010);
    check("R9", "positive disp", target, 32'h0000_1014);
    issue(4'b0000, 4'b0000, 32'h0000_0010, 23'h7FFFF4);
    check("R9", "negative disp", target, 32'h0000_0008);
    issue(4'b0000, 4'b0000, 32'h0000_2000, 23'h000000);
    check("R9", "zero disp", target, 32'h0000_2004);
    issue(4'b1000, 4'b0000, 32'hFFFF_FFFC, 23'h000008);
    check("R9", "wrap past top", target, 32'h0000_0008);
    issue(4'b0000, 4'b0000, 32'h0100_0000, 23'h400000);
    check("R9", "most negative disp", target, 32'h00C0_0004);
    issue(4'b0000, 4'b0000, 32'h0000_0000, 23'h3FFFFF);
    check("R9", "most positive disp", target, 32'h0040_0003);
  endtask

  task automatic testTiming();
    @(negedge clk);
    check("R10", "done idle", {31'b0, done}, 32'd0);
    cond = 4'b0011; {flagN, flagZ, flagC, flagV} = 4'b0100; pc = 32'h80; disp = 23'd4;
    reqValid = 1'b1;
    @(negedge clk);
    check("R10", "done after strobe", {31'b0, done}, 32'd1);
    check("R10", "taken after strobe", {31'b0, taken}, 32'd1);
    cond = 4'b1011;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "done back-to-back", {31'b0, done}, 32'd1);
    check("R10", "second result", {31'b0, taken}, 32'd0);
    @(negedge clk);
    check("R10", "done drops", {31'b0, done}, 32'd0);
  endtask

  task automatic testHold();
    issue(4'b0110, 4'b0000, 32'h0000_0300, 23'd12);
    check("R11", "loaded taken", {31'b0, taken}, 32'd1);
    check("R11", "loaded target", target, 32'h0000_0310);
    cond = 4'b1110; {flagN, flagZ, flagC, flagV} = 4'b1111; pc = 32'hDEAD_0000; disp = 23'h123;
    repeat (4) @(negedge clk);
    check("R11", "taken held", {31'b0, taken}, 32'd1);
    check("R11", "target held", target, 32'h0000_0310);
    check("R11", "done stays low", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    testReset();
    testAllConditions();
    testTarget();
    testTiming();
    testHold();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule